// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a host-side configuration request port and the two places a configuration access can land. It takes one request at a time: bus number, combined device/function number, register offset, a read/write flag and write data. It then decides whether the access targets the bridge's own register file, a device below the bridge, or a device that cannot exist.

Requests for the root bus go straight to the local register port at the requested offset. Requests for any other bus first load the bus, device and function numbers into the upper half of the translated outbound window base, with one strobe on the window port. Only in a later cycle is the plain memory-mapped downstream port accessed, at a fixed configuration-window base plus the offset. The topology filter allows only device 0, function 0 on the root bus, and only slot 0 on the secondary bus that hangs directly off it. Everything else completes at once with no target activity. A rejected read returns all ones.

Top module: `cfg_route`

## Requirements
- R1: While reset is held and in the first cycle after it, `reqReady` is 1 and `rspValid`, `locReq`, `dsReq` and `winWe` are 0.
- R2: A request whose bus equals `rootBus` with devfn 0 drives `locReq` with `locAddr` equal to the offset and `locWrite`/`locWdata` equal to the request. It never raises `dsReq` or `winWe`, and `locReq` and `dsReq` are never high together.
- R3: A request whose bus equals `rootBus` with any nonzero devfn is rejected. No target port is touched, and a read completes with `rspRdata` = 32'hFFFFFFFF.
- R4: A request whose bus equals `secBus` (and not `rootBus`) is rejected when its slot (devfn bits 7..3) is nonzero. Slot 0 with any function (devfn bits 2..0) is forwarded downstream.
- R5: A request for any other bus, or an allowed one on `secBus`, pulses `winWe` for exactly one cycle with `winData` = {bus in bits 31..24, slot in bits 23..19, function in bits 18..16, `WIN_LOW` in bits 15..0}.
- R6: The downstream request `dsReq` first rises in the cycle right after the `winWe` pulse. `dsAddr` is `CFG_BASE` plus the offset, and `dsWrite`/`dsWdata` are equal to the request.
- R7: A rejected write reaches no port (`locReq`, `dsReq` and `winWe` stay 0) and still completes with one `rspValid` pulse.
- R8: A request is accepted on a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is then 0 until the cycle after the `rspValid` pulse, so only one request is outstanding.
- R9: `locReq`/`dsReq` and their address are held steady until the matching ack. The read data present with the ack is returned on `rspRdata` with the single-cycle `rspValid` pulse that follows.
- R10: `rootBus` and `secBus` are live inputs. Changing them moves the filter and the local routing to the new bus numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootBus | input | 8 | Bus number of the root bus |
| secBus | input | 8 | Bus number directly below the root bus |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Router idle, request accepted this cycle if valid |
| reqBus | input | 8 | Target bus number |
| reqDevFn | input | 8 | Slot in bits 7..3, function in bits 2..0 |
| reqOffset | input | 12 | Configuration register byte offset |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data (all ones for rejected reads) |
| locReq | output | 1 | Local register access request, held until ack |
| locWrite | output | 1 | Local access direction |
| locAddr | output | 12 | Local register offset |
| locWdata | output | 32 | Local write data |
| locAck | input | 1 | Local access done |
| locRdata | input | 32 | Local read data, valid with ack |
| winWe | output | 1 | Outbound window 0 base write strobe |
| winData | output | 32 | New outbound window 0 base value |
| dsReq | output | 1 | Downstream access request, held until ack |
| dsWrite | output | 1 | Downstream access direction |
| dsAddr | output | 32 | Downstream address in the configuration window |
| dsWdata | output | 32 | Downstream write data |
| dsAck | input | 1 | Downstream access done |
| dsRdata | input | 32 | Downstream read data, valid with ack |

## Verification
The stimulus table walks bus/devfn pairs that fall on each side of every filter edge. On the root bus it uses devfn 0 and devfn values with only a function bit, only a slot bit, or the top bit set. These separate a check of the whole devfn from a check of the slot field alone. On the secondary bus it pairs a nonzero function with slot 0 against a nonzero slot, which shows that only the slot is filtered there. Buses further down use mixed and all-ones bus/devfn values, so a swapped, shifted or truncated field in the window base shows up as a wrong `winData`. Directed cases add responder wait states, so that a request dropped before its ack can be told apart from a held one. They also renumber the root and secondary buses, which exposes hard-coded bus numbers.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  typedef enum logic [1:0] {
    ROUTE_LOCAL  = 2'd0,
    ROUTE_WINDOW = 2'd1,
    ROUTE_REJECT = 2'd2
  } route_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch the incoming request
    logic loadLocal;  // latch local read data
    logic loadDown;   // latch downstream read data
    logic loadOnes;   // latch the no-device pattern
  } dpCtl_t;

endpackage

// File: rtl/cfg_route_dp.sv
module cfg_route_dp
  import cfg_route_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int SLOT_W = 5,
  parameter int FUNC_W = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] WIN_LOW  = '0,
  localparam int DEVFN_W   = SLOT_W + FUNC_W,
  localparam int BDF_W     = BUS_W + DEVFN_W,
  localparam int WIN_LOW_W = ADDR_W - BDF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [BUS_W-1:0]   rootBus,
  input  logic [BUS_W-1:0]   secBus,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqWdata,
  output route_e             route,
  output logic               writeQ,
  output logic [OFF_W-1:0]   locAddr,
  output logic [DATA_W-1:0]  locWdata,
  input  logic [DATA_W-1:0]  locRdata,
  output logic [ADDR_W-1:0]  dsAddr,
  output logic [DATA_W-1:0]  dsWdata,
  input  logic [DATA_W-1:0]  dsRdata,
  output logic [ADDR_W-1:0]  winData,
  output logic [DATA_W-1:0]  rspRdata
);

  logic [BUS_W-1:0]   busQ;
  logic [DEVFN_W-1:0] devFnQ;
  logic [OFF_W-1:0]   offQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [DATA_W-1:0]  rdataQ;
  logic [SLOT_W-1:0]  reqSlot;

  assign reqSlot = reqDevFn[DEVFN_W-1:FUNC_W];

  // topology filter on the incoming request
  always_comb begin
    if (reqBus == rootBus)
      route = (reqDevFn == '0) ? ROUTE_LOCAL : ROUTE_REJECT;
    else if (reqBus == secBus && reqSlot != '0)
      route = ROUTE_REJECT;
    else
      route = ROUTE_WINDOW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ   <= '0;
      devFnQ <= '0;
      offQ   <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (ctl.capture) begin
      busQ   <= reqBus;
      devFnQ <= reqDevFn;
      offQ   <= reqOffset;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdataQ <= '0;
    else if (ctl.loadOnes)  rdataQ <= '1;
    else if (ctl.loadLocal) rdataQ <= locRdata;
    else if (ctl.loadDown)  rdataQ <= dsRdata;
  end

  assign locAddr  = offQ;
  assign locWdata = wdataQ;
  assign dsWdata  = wdataQ;
  assign dsAddr   = CFG_BASE + {{(ADDR_W-OFF_W){1'b0}}, offQ};
  assign winData  = {busQ, devFnQ, WIN_LOW[WIN_LOW_W-1:0]};
  assign rspRdata = rdataQ;

  // R9: returned data only changes on a load strobe
  a_r9_rdata_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadOnes || ctl.loadLocal || ctl.loadDown) |=> $stable(rdataQ));

endmodule

// File: rtl/cfg_route_ctrl.sv
module cfg_route_ctrl
  import cfg_route_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  output logic   reqReady,
  input  route_e route,
  output dpCtl_t ctl,
  output logic   locReq,
  input  logic   locAck,
  output logic   winWe,
  output logic   dsReq,
  input  logic   dsAck,
  output logic   rspValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCAL, ST_WINSET, ST_DOWN, ST_RESP
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        unique case (route)
          ROUTE_LOCAL:  stateNext = ST_LOCAL;
          ROUTE_WINDOW: stateNext = ST_WINSET;
          default: begin
            ctl.loadOnes = 1'b1;
            stateNext    = ST_RESP;
          end
        endcase
      end
      ST_LOCAL: if (locAck) begin
        ctl.loadLocal = 1'b1;
        stateNext     = ST_RESP;
      end
      ST_WINSET: stateNext = ST_DOWN;
      ST_DOWN: if (dsAck) begin
        ctl.loadDown = 1'b1;
        stateNext    = ST_RESP;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign locReq   = (state == ST_LOCAL);
  assign winWe    = (state == ST_WINSET);
  assign dsReq    = (state == ST_DOWN);
  assign rspValid = (state == ST_RESP);

  // R8: nothing new is taken while a request is in flight
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R5: the window base strobe is a single cycle
  a_r5_win_single: assert property (@(posedge clk) disable iff (!rstN)
    winWe |=> !winWe);

  // R7: a rejected request touches no target
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && route == ROUTE_REJECT) |=> (!locReq && !dsReq && !winWe && rspValid));

endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_route_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int SLOT_W = 5,
  parameter int FUNC_W = 3,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] WIN_LOW  = '0,
  localparam int DEVFN_W = SLOT_W + FUNC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BUS_W-1:0]   rootBus,
  input  logic [BUS_W-1:0]   secBus,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspRdata,
  output logic               locReq,
  output logic               locWrite,
  output logic [OFF_W-1:0]   locAddr,
  output logic [DATA_W-1:0]  locWdata,
  input  logic               locAck,
  input  logic [DATA_W-1:0]  locRdata,
  output logic               winWe,
  output logic [ADDR_W-1:0]  winData,
  output logic               dsReq,
  output logic               dsWrite,
  output logic [ADDR_W-1:0]  dsAddr,
  output logic [DATA_W-1:0]  dsWdata,
  input  logic               dsAck,
  input  logic [DATA_W-1:0]  dsRdata
);

  dpCtl_t ctl;
  route_e route;
  logic   writeQ;

  cfg_route_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .route    (route),
    .ctl      (ctl),
    .locReq   (locReq),
    .locAck   (locAck),
    .winWe    (winWe),
    .dsReq    (dsReq),
    .dsAck    (dsAck),
    .rspValid (rspValid)
  );

  cfg_route_dp #(
    .BUS_W (BUS_W), .SLOT_W (SLOT_W), .FUNC_W (FUNC_W), .OFF_W (OFF_W),
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .CFG_BASE (CFG_BASE), .WIN_LOW (WIN_LOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rootBus   (rootBus),
    .secBus    (secBus),
    .reqBus    (reqBus),
    .reqDevFn  (reqDevFn),
    .reqOffset (reqOffset),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .route     (route),
    .writeQ    (writeQ),
    .locAddr   (locAddr),
    .locWdata  (locWdata),
    .locRdata  (locRdata),
    .dsAddr    (dsAddr),
    .dsWdata   (dsWdata),
    .dsRdata   (dsRdata),
    .winData   (winData),
    .rspRdata  (rspRdata)
  );

  assign locWrite = writeQ;
  assign dsWrite  = writeQ;

  // R2: at most one target is addressed at a time
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    !(locReq && dsReq));

  // R6: the downstream access starts right after the window base update
  a_r6_down_after_win: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dsReq) |-> $past(winWe));

  // R9: a pending downstream access holds its address until acked
  a_r9_ds_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dsReq && !dsAck) |=> (dsReq && $stable(dsAddr)));

  // R9: a pending local access holds its address until acked
  a_r9_loc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (locReq && !locAck) |=> (locReq && $stable(locAddr)));

endmodule

// File: tb/cfg_route_tb.sv
module cfg_route_tb;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rootBus = 8'h00, secBus = 8'h01;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqBus = '0, reqDevFn = '0;
  logic [11:0] reqOffset = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, rspValid, locReq, locWrite, winWe, dsReq, dsWrite;
  logic [31:0] rspRdata, locWdata, winData, dsAddr, dsWdata;
  logic [11:0] locAddr;
  logic locAck = 1'b0, dsAck = 1'b0;
  logic [31:0] locRdata = '0, dsRdata = '0;

  always #10 clk = ~clk;

  cfg_route u_dut (
    .clk(clk), .rstN(rstN), .rootBus(rootBus), .secBus(secBus),
    .reqValid(reqValid), .reqReady(reqReady), .reqBus(reqBus), .reqDevFn(reqDevFn),
    .reqOffset(reqOffset), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .locReq(locReq), .locWrite(locWrite), .locAddr(locAddr), .locWdata(locWdata),
    .locAck(locAck), .locRdata(locRdata),
    .winWe(winWe), .winData(winData),
    .dsReq(dsReq), .dsWrite(dsWrite), .dsAddr(dsAddr), .dsWdata(dsWdata),
    .dsAck(dsAck), .dsRdata(dsRdata)
  );

  int checks = 0, fails = 0;
  int ackDelay = 0, locWait = 0, dsWait = 0, cyc = 0;
  int locCount, dsCount, winCount, winCycle, dsFirst;
  logic [31:0] winSeen, lastDsAddr, lastDsWdata, lastLocWdata;
  logic [11:0] lastLocAddr;
  logic lastLocWrite, lastDsWrite, dsPrev;

  // responders and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (locReq && !locAck) begin
      if (locWait >= ackDelay) begin
        locAck <= 1'b1; locRdata <= 32'hA000_0000 | {20'h0, locAddr}; locWait <= 0;
        locCount <= locCount + 1; lastLocAddr <= locAddr;
        lastLocWdata <= locWdata; lastLocWrite <= locWrite;
      end else locWait <= locWait + 1;
    end else locAck <= 1'b0;
    if (dsReq && !dsAck) begin
      if (dsWait >= ackDelay) begin
        dsAck <= 1'b1; dsRdata <= 32'hD000_0000 ^ dsAddr; dsWait <= 0;
        dsCount <= dsCount + 1; lastDsAddr <= dsAddr;
        lastDsWdata <= dsWdata; lastDsWrite <= dsWrite;
      end else dsWait <= dsWait + 1;
    end else dsAck <= 1'b0;
    if (winWe) begin winCount <= winCount + 1; winSeen <= winData; winCycle <= cyc; end
    if (dsReq && !dsPrev) dsFirst <= cyc;
    dsPrev <= dsReq;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doTxn(input logic [7:0] bus, input logic [7:0] devfn, input logic [11:0] off,
                       input logic wr, input logic [31:0] wd, output logic [31:0] rd,
                       output logic busyOk, output logic gotRsp);
    @(negedge clk);
    locCount = 0; dsCount = 0; winCount = 0; winCycle = -1; dsFirst = -1;
    reqBus = bus; reqDevFn = devfn; reqOffset = off; reqWrite = wr; reqWdata = wd;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    busyOk = !reqReady;
    for (int k = 0; k < 40 && !rspValid; k++) @(negedge clk);
    gotRsp = rspValid;
    rd = rspRdata;
    @(negedge clk);
    chk(!rspValid, "R9", {31'h0, rspValid}, 32'h0);
  endtask

  // bus, devfn, offset, write, kind (0 local, 1 downstream, 2 reject)
  localparam int NV = 12;
  localparam logic [30:0] VECS [0:NV-1] = '{
    {8'h00, 8'h00, 12'h010, 1'b0, 2'd0},
    {8'h00, 8'h00, 12'h004, 1'b1, 2'd0},
    {8'h00, 8'h01, 12'h000, 1'b0, 2'd2},
    {8'h00, 8'h08, 12'h020, 1'b1, 2'd2},
    {8'h01, 8'h00, 12'h008, 1'b0, 2'd1},
    {8'h01, 8'h05, 12'h100, 1'b0, 2'd1},
    {8'h01, 8'h08, 12'h00C, 1'b0, 2'd2},
    {8'h01, 8'hF9, 12'h040, 1'b1, 2'd2},
    {8'h02, 8'h1B, 12'h3FC, 1'b0, 2'd1},
    {8'hFF, 8'hFF, 12'hFFC, 1'b0, 2'd1},
    {8'h05, 8'h42, 12'h014, 1'b1, 2'd1},
    {8'h00, 8'h80, 12'h000, 1'b0, 2'd2}
  };

  task automatic runVec(input logic [7:0] bus, input logic [7:0] devfn, input logic [11:0] off,
                        input logic wr, input logic [1:0] kind);
    logic [31:0] rd, wd;
    logic busyOk, gotRsp;
    string rj;
    wd = {bus, devfn, 4'h5, off};
    doTxn(bus, devfn, off, wr, wd, rd, busyOk, gotRsp);
    chk(busyOk, "R8", {31'h0, busyOk}, 32'h1);
    chk(gotRsp, "R7", {31'h0, gotRsp}, 32'h1);
    if (kind == 2'd0) begin
      chk(locCount == 1 && dsCount == 0 && winCount == 0, "R2", locCount, 1);
      chk(lastLocAddr == off && lastLocWrite == wr, "R2", {20'h0, lastLocAddr}, {20'h0, off});
      if (wr) chk(lastLocWdata == wd, "R2", lastLocWdata, wd);
      else    chk(rd == (32'hA000_0000 | {20'h0, off}), "R9", rd, 32'hA000_0000 | {20'h0, off});
    end else if (kind == 2'd1) begin
      chk(winCount == 1 && locCount == 0, "R5", winCount, 1);
      chk(winSeen == {bus, devfn, 16'h0}, "R5", winSeen, {bus, devfn, 16'h0});
      chk(dsCount == 1 && dsFirst == winCycle + 1, "R6", dsFirst, winCycle + 1);
      chk(lastDsAddr == BASE + {20'h0, off} && lastDsWrite == wr, "R6", lastDsAddr, BASE + {20'h0, off});
      if (wr) chk(lastDsWdata == wd, "R6", lastDsWdata, wd);
      else    chk(rd == (32'hD000_0000 ^ (BASE + {20'h0, off})), "R9", rd, 32'hD000_0000 ^ (BASE + {20'h0, off}));
    end else begin
      rj = (bus == rootBus) ? "R3" : "R4";
      if (wr) rj = "R7";
      chk(locCount == 0 && dsCount == 0 && winCount == 0, rj, locCount + dsCount + winCount, 0);
      if (!wr) chk(rd == 32'hFFFF_FFFF, rj, rd, 32'hFFFF_FFFF);
    end
  endtask

  bit wdExpired = 0;

  initial begin
    #(20 * 150000);
    wdExpired = 1;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic busyOk, gotRsp;
    locCount = 0; dsCount = 0; winCount = 0; dsPrev = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(reqReady && !rspValid && !locReq && !dsReq && !winWe, "R1",
        {27'h0, reqReady, rspValid, locReq, dsReq, winWe}, 32'h10);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !locReq && !dsReq && !winWe, "R1",
        {27'h0, reqReady, rspValid, locReq, dsReq, winWe}, 32'h10);

    for (int i = 0; i < NV; i++)
      runVec(VECS[i][30:23], VECS[i][22:15], VECS[i][14:3], VECS[i][2], VECS[i][1:0]);

    // R9: wait states on both targets
    ackDelay = 3;
    runVec(8'h00, 8'h00, 12'h0A8, 1'b0, 2'd0);
    runVec(8'h07, 8'h10, 12'h044, 1'b0, 2'd1);
    ackDelay = 0;

    // R10: renumbered root and secondary buses
    rootBus = 8'h03; secBus = 8'h04;
    runVec(8'h00, 8'h08, 12'h018, 1'b0, 2'd1);  // old root bus now plain downstream
    runVec(8'h03, 8'h00, 12'h01C, 1'b0, 2'd0);  // R10 new root local
    runVec(8'h03, 8'h02, 12'h01C, 1'b0, 2'd2);  // R10 new root filter
    runVec(8'h04, 8'h10, 12'h000, 1'b0, 2'd2);  // R10 new secondary slot filter
    runVec(8'h04, 8'h03, 12'h000, 1'b0, 2'd1);  // R4 function on slot 0 allowed
    runVec(8'h01, 8'h08, 12'h000, 1'b0, 2'd1);  // old secondary no longer filtered

    // R8: back-to-back request held valid is taken only after completion
    rootBus = 8'h00; secBus = 8'h01;
    doTxn(8'h00, 8'h00, 12'h000, 1'b0, 32'h0, rd, busyOk, gotRsp);
    chk(busyOk && gotRsp, "R8", {30'h0, busyOk, gotRsp}, 32'h3);

    if (!wdExpired) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule